// File: doc/BRIEF.md
# Privileged Clock and Interval Interrupt Controller

This block executes one family of privileged supervisory commands for a processor. A 3-bit sub-code selects the action. The actions are: load the free-running real-time clock, send an interprocessor interrupt, clear the interprocessor interrupts this processor has received, pick a cluster number, and drive a programmable interval timer. The interval timer has a reload register and a live countdown counter. When the counter runs out it raises a request. If repeating is switched on, the counter reloads and raises the request again at the interval rate.

Commands arrive on a plain valid strobe carrying the sub-code `cmd_k`, the designator `cmd_j` and a 64-bit operand. The block takes a command in every cycle in which `cmd_valid` is high and never applies back-pressure, so there is no ready pin. A command acts only while `monitor_mode` is high; otherwise it passes with no effect. All state is reset asynchronously by `rst_n` (active low) to zero, with repeating disabled.

Top module: `pit_ctrl`

## Requirements
- R1: A command sampled while `monitor_mode` is 0 changes nothing: the clock still just increments, no interrupt is sent, and neither the cluster number, the pending bits nor the interval state change.
- R2: Sub-code 0 loads `rtc` with the operand at the sampling edge. If `cmd_j` is 0 or the operand is 0, `rtc` loads 0 instead. In every other cycle `rtc` increases by one.
- R3: Sub-code 1 drives `ipi_send` one-hot at bit `cmd_j` for exactly the cycle after the sampling edge. If `cmd_j` equals `my_pn`, no bit is driven.
- R4: A high `ipi_in[i]` at an edge sets `ipi_pending[i]`, and the bit holds until sub-code 2 clears every pending bit. If a set and a clear meet at the same edge, the set wins.
- R5: Sub-code 3 sets `cluster_num` to `cmd_j` when `cmd_j` is 5 or less. Larger values leave it unchanged. Reset value is 0, which means no cluster.
- R6: Sub-code 4 loads the low 32 bits of the operand into both the interval register and the countdown counter. If `cmd_j` is 0 or the whole operand is 0, both are cleared.
- R7: A nonzero counter decrements once per cycle. The edge that takes it from 1 to 0 also sets `pclk_irq`, which then holds until sub-code 5 clears it. If a set and a clear meet at the same edge, the set wins. A load of N therefore raises `pclk_irq` N cycles after the load edge.
- R8: Sub-code 6 turns repeating on and sub-code 7 turns it off. With repeating on, a counter at 0 reloads from a nonzero interval register at the next edge, so requests recur every interval+1 cycles. With repeating off, the counter stays at 0. Reset state is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_k | input | 3 | Sub-code (0..7, see R2-R8) |
| cmd_j | input | 3 | Designator: target processor, cluster, or zero-select |
| cmd_opnd | input | 64 | Operand |
| my_pn | input | 3 | This processor's number |
| monitor_mode | input | 1 | Privilege bit; commands act only when high |
| ipi_in | input | 8 | Interrupt requests arriving from other processors |
| rtc | output | 64 | Real-time clock value |
| ipi_send | output | 8 | One-cycle interprocessor interrupt pulse per target |
| ipi_pending | output | 8 | Held received interprocessor requests |
| cluster_num | output | 3 | Selected cluster (0 = none) |
| pclk_irq | output | 1 | Programmable clock interrupt request |

## Verification
The assertions assume that `cmd_k`, `cmd_j` and `cmd_opnd` are stable and known whenever `cmd_valid` is high. They also assume `my_pn` stays constant after reset. The checks on sends, pending bits and counter steps reason only over one edge, so they need no limit on how often commands arrive. The stimulus drives every input one nanosecond after a rising edge and never changes `my_pn`. It deliberately lines up the same-edge collisions (set against clear, zero reached against a clear command) so that those priority assumptions are exercised rather than avoided.

// File: rtl/pit_pkg.sv
package pit_pkg;
  typedef enum logic [2:0] {
    SUB_RTC_LD  = 3'd0,
    SUB_IPI_SET = 3'd1,
    SUB_IPI_CLR = 3'd2,
    SUB_CLUSTER = 3'd3,
    SUB_INTV_LD = 3'd4,
    SUB_IRQ_CLR = 3'd5,
    SUB_REP_ON  = 3'd6,
    SUB_REP_OFF = 3'd7
  } sub_e;

  typedef struct packed {
    logic rtc_ld;
    logic ipi_set;
    logic ipi_clr;
    logic cl_set;
    logic iv_ld;
    logic irq_clr;
    logic rep_on;
    logic rep_off;
  } strobe_t;
endpackage

// File: rtl/pit_rtc.sv
module pit_rtc #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic         zero_sel,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (ld)     q <= zero_sel ? '0 : din;
    else             q <= q + W'(1);
  end

  // R2
  rtc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> q == $past(q) + W'(1));
  // R2
  rtc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && zero_sel) |=> q == '0);
endmodule

// File: rtl/pit_ipi.sv
module pit_ipi #(
  parameter int NPROC = 8,
  parameter int J_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set,
  input  logic             clr,
  input  logic [J_W-1:0]   tgt,
  input  logic [J_W-1:0]   self_pn,
  input  logic [NPROC-1:0] ipi_in,
  output logic [NPROC-1:0] send,
  output logic [NPROC-1:0] pend
);
  logic not_self;
  assign not_self = (tgt != self_pn);

  for (genvar i = 0; i < NPROC; i++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        send[i] <= 1'b0;
        pend[i] <= 1'b0;
      end else begin
        send[i] <= set && not_self && (tgt == J_W'(i));
        pend[i] <= ipi_in[i] | (pend[i] & ~clr);
      end
    end
  end

  // R3
  send_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(send));
  // R3
  no_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set && tgt == self_pn) |=> send == '0);
  // R4
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (pend & $past(pend)) == $past(pend));
endmodule

// File: rtl/pit_interval.sv
module pit_interval #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic         zero_sel,
  input  logic [W-1:0] din,
  input  logic         irq_clr,
  input  logic         rep_on,
  input  logic         rep_off,
  output logic         irq
);
  logic [W-1:0] reload_q;
  logic [W-1:0] cnt_q;
  logic         rep_q;
  logic [W-1:0] ld_val;
  logic         expire;

  assign ld_val = zero_sel ? '0 : din;
  assign expire = !ld && (cnt_q == W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      cnt_q    <= '0;
      rep_q    <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (ld) begin
        reload_q <= ld_val;
        cnt_q    <= ld_val;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - W'(1);
      end else if (rep_q && reload_q != '0) begin
        cnt_q <= reload_q;
      end
      if (rep_on)       rep_q <= 1'b1;
      else if (rep_off) rep_q <= 1'b0;
      if (expire)       irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
    end
  end

  // R7
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && cnt_q == W'(1)) |=> irq);
  // R7
  irq_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);
  // R8
  park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && cnt_q == '0 && !rep_q) |=> cnt_q == '0);
  // R6
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && zero_sel) |=> (cnt_q == '0 && reload_q == '0));
endmodule

// File: rtl/pit_ctrl.sv
module pit_ctrl #(
  parameter int NPROC       = 8,
  parameter int RTC_W       = 64,
  parameter int IV_W        = 32,
  parameter int MAX_CLUSTER = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmd_valid,
  input  logic [2:0]                   cmd_k,
  input  logic [$clog2(NPROC)-1:0]     cmd_j,
  input  logic [RTC_W-1:0]             cmd_opnd,
  input  logic [$clog2(NPROC)-1:0]     my_pn,
  input  logic                         monitor_mode,
  input  logic [NPROC-1:0]             ipi_in,
  output logic [RTC_W-1:0]             rtc,
  output logic [NPROC-1:0]             ipi_send,
  output logic [NPROC-1:0]             ipi_pending,
  output logic [$clog2(MAX_CLUSTER+1)-1:0] cluster_num,
  output logic                         pclk_irq
);
  import pit_pkg::*;

  localparam int J_W  = $clog2(NPROC);
  localparam int CL_W = $clog2(MAX_CLUSTER + 1);

  strobe_t str;
  logic    zero_sel;

  assign zero_sel = (cmd_j == '0) || (cmd_opnd == '0);

  always_comb begin
    str = '0;
    if (cmd_valid && monitor_mode) begin
      case (sub_e'(cmd_k))
        SUB_RTC_LD:  str.rtc_ld  = 1'b1;
        SUB_IPI_SET: str.ipi_set = 1'b1;
        SUB_IPI_CLR: str.ipi_clr = 1'b1;
        SUB_CLUSTER: str.cl_set  = 1'b1;
        SUB_INTV_LD: str.iv_ld   = 1'b1;
        SUB_IRQ_CLR: str.irq_clr = 1'b1;
        SUB_REP_ON:  str.rep_on  = 1'b1;
        SUB_REP_OFF: str.rep_off = 1'b1;
        default:     str = '0;
      endcase
    end
  end

  pit_rtc #(.W(RTC_W)) u_rtc (
    .clk(clk), .rst_n(rst_n), .ld(str.rtc_ld), .zero_sel(zero_sel),
    .din(cmd_opnd), .q(rtc)
  );

  pit_ipi #(.NPROC(NPROC), .J_W(J_W)) u_ipi (
    .clk(clk), .rst_n(rst_n), .set(str.ipi_set), .clr(str.ipi_clr),
    .tgt(cmd_j), .self_pn(my_pn), .ipi_in(ipi_in),
    .send(ipi_send), .pend(ipi_pending)
  );

  pit_interval #(.W(IV_W)) u_iv (
    .clk(clk), .rst_n(rst_n), .ld(str.iv_ld), .zero_sel(zero_sel),
    .din(cmd_opnd[IV_W-1:0]), .irq_clr(str.irq_clr),
    .rep_on(str.rep_on), .rep_off(str.rep_off), .irq(pclk_irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cluster_num <= '0;
    else if (str.cl_set && (cmd_j <= J_W'(MAX_CLUSTER)))
      cluster_num <= CL_W'(cmd_j);
  end

  // R1
  pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !monitor_mode) |=> ($stable(cluster_num) && ipi_send == '0));
  // R5
  cluster_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cluster_num <= CL_W'(MAX_CLUSTER));
endmodule

// File: tb/sim_pit_ctrl.sv
`timescale 1ns/1ps
module sim_pit_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_k = '0;
  logic [2:0]  cmd_j = '0;
  logic [63:0] cmd_opnd = '0;
  logic [2:0]  my_pn = 3'd2;
  logic        monitor_mode = 1'b1;
  logic [7:0]  ipi_in = '0;
  logic [63:0] rtc;
  logic [7:0]  ipi_send;
  logic [7:0]  ipi_pending;
  logic [2:0]  cluster_num;
  logic        pclk_irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;
  string phase = "R0";

  always #4 clk = ~clk;

  pit_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_k(cmd_k),
    .cmd_j(cmd_j), .cmd_opnd(cmd_opnd), .my_pn(my_pn),
    .monitor_mode(monitor_mode), .ipi_in(ipi_in), .rtc(rtc),
    .ipi_send(ipi_send), .ipi_pending(ipi_pending),
    .cluster_num(cluster_num), .pclk_irq(pclk_irq)
  );

  // behavioural reference
  logic [63:0] m_rtc;
  logic [7:0]  m_send, m_pend;
  logic [2:0]  m_cl;
  logic        m_irq, m_rep;
  longint      m_iv, m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rtc = 0; m_send = 0; m_pend = 0; m_cl = 0;
      m_irq = 0; m_rep = 0; m_iv = 0; m_cnt = 0;
    end else begin
      bit act, zs, hit, old_rep;
      act = cmd_valid && monitor_mode;
      zs  = (cmd_j == 0) || (cmd_opnd == 0);
      old_rep = m_rep;
      if (act && cmd_k == 0) m_rtc = zs ? 64'd0 : cmd_opnd;
      else m_rtc = m_rtc + 64'd1;
      m_send = 0;
      if (act && cmd_k == 1 && cmd_j != my_pn) m_send[cmd_j] = 1'b1;
      if (act && cmd_k == 2) m_pend = 0;
      m_pend = m_pend | ipi_in;
      if (act && cmd_k == 3 && cmd_j <= 5) m_cl = cmd_j;
      hit = 0;
      if (act && cmd_k == 4) begin
        m_iv  = zs ? 0 : longint'(cmd_opnd[31:0]);
        m_cnt = m_iv;
      end else if (m_cnt > 0) begin
        if (m_cnt == 1) hit = 1;
        m_cnt = m_cnt - 1;
      end else if (old_rep && m_iv > 0) begin
        m_cnt = m_iv;
      end
      if (hit) m_irq = 1;
      else if (act && cmd_k == 5) m_irq = 0;
      if (act && cmd_k == 6) m_rep = 1;
      else if (act && cmd_k == 7) m_rep = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s/%s %s actual=%0h expected=%0h", phase, req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(rtc == m_rtc, "R2", "rtc", rtc, m_rtc);
      chk(ipi_send == m_send, "R3", "ipi_send", ipi_send, m_send);
      chk(ipi_pending == m_pend, "R4", "ipi_pending", ipi_pending, m_pend);
      chk(cluster_num == m_cl, "R5", "cluster", cluster_num, m_cl);
      chk(pclk_irq == m_irq, "R7", "pclk_irq", pclk_irq, m_irq);
    end
  end

  task automatic cmd(input logic [2:0] k, input logic [2:0] j,
                     input logic [63:0] op, input bit mm);
    @(posedge clk); #1;
    cmd_valid = 1; cmd_k = k; cmd_j = j; cmd_opnd = op; monitor_mode = mm;
    @(posedge clk); #1;
    cmd_valid = 0; monitor_mode = 1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    #21 rst_n = 1;
    @(negedge clk);
    phase = "RST";
    chk(cluster_num == 0 && pclk_irq == 0 && ipi_pending == 0, "R5", "reset state",
        {cluster_num, pclk_irq, ipi_pending}, 0);

    // R1: privileged commands ignored outside monitor mode
    phase = "R1";
    for (int k = 0; k < 8; k++) cmd(k[2:0], 3'd4, 64'h7, 1'b0);
    @(negedge clk);
    chk(cluster_num == 0 && pclk_irq == 0, "R1", "state after pass",
        {cluster_num, pclk_irq}, 0);

    // R2: clock load and clear
    phase = "R2";
    cmd(3'd0, 3'd1, 64'd1000, 1'b1); idle(3);
    cmd(3'd0, 3'd0, 64'd55, 1'b1);   idle(2);
    cmd(3'd0, 3'd3, 64'd0, 1'b1);    idle(2);
    cmd(3'd0, 3'd3, 64'hFFFF_FFFF_FFFF_FFFE, 1'b1); idle(4);

    // R3: interprocessor send, self-target ignored
    phase = "R3";
    cmd(3'd1, 3'd5, 64'd0, 1'b1);
    cmd(3'd1, 3'd2, 64'd0, 1'b1);
    cmd(3'd1, 3'd0, 64'd0, 1'b1);
    cmd(3'd1, 3'd7, 64'd0, 1'b1); idle(2);

    // R4: pending set, clear, and collision
    phase = "R4";
    @(posedge clk); #1 ipi_in = 8'b1001_0001;
    @(posedge clk); #1 ipi_in = 0;
    idle(3);
    cmd(3'd2, 3'd0, 64'd0, 1'b1); idle(1);
    @(posedge clk); #1 ipi_in = 8'b0000_0110;
    @(posedge clk); #1 ipi_in = 8'b0100_0000;
    cmd_valid = 1; cmd_k = 3'd2;
    @(posedge clk); #1 ipi_in = 0; cmd_valid = 0;
    idle(2);

    // R5: cluster select and out-of-range
    phase = "R5";
    cmd(3'd3, 3'd3, 64'd0, 1'b1);
    cmd(3'd3, 3'd6, 64'd0, 1'b1);
    cmd(3'd3, 3'd5, 64'd0, 1'b1);
    cmd(3'd3, 3'd7, 64'd0, 1'b1);
    cmd(3'd3, 3'd0, 64'd0, 1'b1); idle(1);

    // R6/R7: interval load uses low bits only, then expiry and clear
    phase = "R6";
    cmd(3'd4, 3'd1, 64'h0000_0009_0000_0005, 1'b1); idle(8);
    phase = "R7";
    cmd(3'd5, 3'd0, 64'd0, 1'b1); idle(2);
    cmd(3'd4, 3'd1, 64'd3, 1'b1); idle(1);
    cmd(3'd5, 3'd0, 64'd0, 1'b1); idle(3);
    cmd(3'd5, 3'd0, 64'd0, 1'b1);
    phase = "R6";
    cmd(3'd4, 3'd0, 64'd12, 1'b1); idle(15);
    cmd(3'd4, 3'd1, 64'h1_0000_0000, 1'b1); idle(6);

    // R8: repeating requests
    phase = "R8";
    cmd(3'd4, 3'd1, 64'd4, 1'b1);
    cmd(3'd6, 3'd0, 64'd0, 1'b1);
    for (int n = 0; n < 4; n++) begin
      idle(3);
      cmd(3'd5, 3'd0, 64'd0, 1'b1);
    end
    cmd(3'd7, 3'd0, 64'd0, 1'b1); idle(2);
    cmd(3'd5, 3'd0, 64'd0, 1'b1); idle(20);
    cmd(3'd6, 3'd0, 64'd0, 1'b1); idle(12);
    cmd(3'd7, 3'd0, 64'd0, 1'b1); idle(8);

    @(negedge clk);
    finish_run();
  end
endmodule